// File: doc/BRIEF.md
# Paired-Shift Instruction Buffer

This block is the queue that sits between the instruction fetch stage and the dispatch stage. Each cycle fetch offers a group of up to four instructions together with a count of how many are useful. The count drops below four when the group was cut short by the end of a cache line or by a taken branch. Dispatch looks at the head of the queue. It sees up to four instructions in program order and tells the block how many it took. Instructions stay in the buffer for as long as dispatch falls behind fetch.

Storage is organised as four pairs of slots. Space is handed out one whole pair at a time, and the contents move toward the head by whole pairs. An odd fetch count therefore occupies a pair with one empty slot. An odd dispatch count leaves the second instruction of the head pair in place, marked by its own valid bit. A pair leaves the head only once none of its slots holds a live instruction. Fetch is held back unless the whole group fits in free pairs. A flush input, raised on a branch redirect, empties the buffer.

Top module: `ibuf_pair_queue`

## Requirements
- R1: After a synchronous reset the buffer is empty: `dsp_avail` is 0 and `fet_ready` is 1 for any fetch count from 0 to 4.
- R2: `dsp_avail` equals the smaller of the number of buffered instructions and 4. Lane j of `dsp_instr` (bits j*32 up to j*32+31) carries the j-th oldest buffered instruction, for j below `dsp_avail`.
- R3: `fet_ready` is 1 exactly when ceil(`fet_cnt`/2) is no greater than the number of pairs that are free at the start of the cycle. When it is 0, nothing is written.
- R4: An accepted group of n instructions takes ceil(n/2) pairs. A pair left half filled by an odd count receives no later instruction, so four pairs in use block any further fetch.
- R5: An odd dispatch count leaves the remaining instruction of a pair in place. The next cycle presents it first, followed by the rest in program order.
- R6: When `flush` is 1, every instruction, including any group offered by fetch in that cycle, is discarded at the next clock edge, and `dsp_avail` reads 0 afterwards.
- R7: A `dsp_take` larger than `dsp_avail` consumes only `dsp_avail` instructions.
- R8: A `fet_cnt` of 0 writes nothing, and the buffer never grows in a cycle without an accepted group.
- R9: When dispatch consumes and fetch writes in the same cycle, the new group is placed after all instructions that remain, and program order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Redirect: discard all contents and the current fetch group |
| fet_cnt | input | 3 | Number of useful instructions in the fetch group (0 to 4) |
| fet_instr | input | 128 | Fetch group, lane l at bits l*32 +: 32 |
| fet_ready | output | 1 | Fetch group fits and is accepted at the edge |
| dsp_avail | output | 3 | Instructions presented to dispatch (0 to 4) |
| dsp_instr | output | 128 | Head instructions in program order, lane j at bits j*32 +: 32 |
| dsp_take | input | 3 | Number of head instructions dispatch consumes this cycle |

## Verification
A wrong valid bit or a wrong shift amount shows up at the dispatch lanes one cycle after the edge that caused it. It appears either as an instruction out of order, or as a repeated or missing instruction when the head is compared with the stream of accepted fetches. An occupancy that drifts from the real pair usage appears at `fet_ready` as soon as fetch offers a group that needs the last free pair. The odd-count paths are covered by directed sequences first and then by a long mix of random counts and occasional flushes, all checked against an independent pair model.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;

    localparam int IB_INSTR_W = 32;

    typedef logic [IB_INSTR_W-1:0] instr_t;

    typedef struct packed {
        logic   vld;
        instr_t op;
    } slot_t;

endpackage

// File: rtl/ibuf_head_view.sv
module ibuf_head_view
    import ibuf_pkg::*;
#(
    parameter  int SLOTS = 8,
    parameter  int LANES = 4,
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int SW    = $clog2(SLOTS + 1)
) (
    input  slot_t [SLOTS-1:0] slots,
    input  logic  [CNT_W-1:0] take_req,
    output logic  [CNT_W-1:0] avail,
    output instr_t            lanes [LANES],
    output logic  [SLOTS-1:0] consume
);

    logic [SW-1:0]    total;
    logic [SW-1:0]    rank;
    logic [CNT_W-1:0] take_c;

    always_comb begin
        total = '0;
        for (int i = 0; i < SLOTS; i++) begin
            total = total + SW'(slots[i].vld);
        end
        avail  = (total > SW'(LANES)) ? CNT_W'(LANES) : CNT_W'(total);
        take_c = (take_req > avail) ? avail : take_req;

        rank    = '0;
        consume = '0;
        for (int j = 0; j < LANES; j++) begin
            lanes[j] = '0;
        end
        for (int i = 0; i < SLOTS; i++) begin
            if (slots[i].vld) begin
                for (int j = 0; j < LANES; j++) begin
                    if (rank == SW'(j)) begin
                        lanes[j] = slots[i].op;
                    end
                end
                if (rank < SW'(take_c)) begin
                    consume[i] = 1'b1;
                end
                rank = rank + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ibuf_pair_compact.sv
module ibuf_pair_compact
    import ibuf_pkg::*;
#(
    parameter  int NUM_PAIRS = 4,
    localparam int SLOTS     = 2 * NUM_PAIRS,
    localparam int OW        = $clog2(NUM_PAIRS + 1)
) (
    input  slot_t [SLOTS-1:0] slots,
    input  logic  [SLOTS-1:0] consume,
    output slot_t [SLOTS-1:0] kept,
    output logic  [OW-1:0]    occ_after
);

    slot_t [SLOTS-1:0] cleared;
    logic  [OW-1:0]    drop;
    logic              stop;

    always_comb begin
        cleared = slots;
        for (int i = 0; i < SLOTS; i++) begin
            cleared[i].vld = slots[i].vld & ~consume[i];
        end

        drop      = '0;
        stop      = 1'b0;
        occ_after = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (cleared[2*p].vld || cleared[2*p+1].vld) begin
                occ_after = occ_after + 1'b1;
                stop      = 1'b1;
            end else if (!stop) begin
                drop = drop + 1'b1;
            end
        end

        kept = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            for (int d = 0; d < NUM_PAIRS - p; d++) begin
                if (drop == OW'(d)) begin
                    kept[2*p+:2] = cleared[2*(p+d)+:2];
                end
            end
        end
    end

endmodule

// File: rtl/ibuf_pair_fill.sv
module ibuf_pair_fill
    import ibuf_pkg::*;
#(
    parameter  int NUM_PAIRS = 4,
    parameter  int LANES     = 4,
    localparam int SLOTS     = 2 * NUM_PAIRS,
    localparam int CNT_W     = $clog2(LANES + 1),
    localparam int OW        = $clog2(NUM_PAIRS + 1)
) (
    input  slot_t [SLOTS-1:0]            base,
    input  logic  [OW-1:0]               occ,
    input  logic                         wr_en,
    input  logic  [CNT_W-1:0]            cnt,
    input  logic  [LANES*IB_INSTR_W-1:0] group,
    output slot_t [SLOTS-1:0]            filled
);

    always_comb begin
        filled = base;
        for (int l = 0; l < LANES; l++) begin
            for (int s = 0; s < SLOTS; s++) begin
                if (wr_en && (CNT_W'(l) < cnt) && (int'(occ) * 2 + l == s)) begin
                    filled[s].vld = 1'b1;
                    filled[s].op  = group[l*IB_INSTR_W +: IB_INSTR_W];
                end
            end
        end
    end

endmodule

// File: rtl/ibuf_pair_queue.sv
module ibuf_pair_queue
    import ibuf_pkg::*;
#(
    parameter  int NUM_PAIRS = 4,
    parameter  int LANES     = 4,
    localparam int SLOTS     = 2 * NUM_PAIRS,
    localparam int CNT_W     = $clog2(LANES + 1),
    localparam int OW        = $clog2(NUM_PAIRS + 1),
    localparam int BUS_W     = LANES * IB_INSTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [CNT_W-1:0] fet_cnt,
    input  logic [BUS_W-1:0] fet_instr,
    output logic             fet_ready,
    output logic [CNT_W-1:0] dsp_avail,
    output logic [BUS_W-1:0] dsp_instr,
    input  logic [CNT_W-1:0] dsp_take
);

    slot_t [SLOTS-1:0] slots_q;
    slot_t [SLOTS-1:0] kept;
    slot_t [SLOTS-1:0] filled;
    logic  [SLOTS-1:0] consume;
    instr_t            lanes [LANES];
    logic  [OW-1:0]    occ_q;
    logic  [OW-1:0]    occ_after;
    logic  [OW-1:0]    need;
    logic  [CNT_W-1:0] take_eff;
    logic              wr_en;

    always_comb begin
        occ_q = '0;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (slots_q[2*p].vld || slots_q[2*p+1].vld) begin
                occ_q = occ_q + 1'b1;
            end
        end
        need      = OW'((int'(fet_cnt) + 1) / 2);
        fet_ready = (need <= OW'(NUM_PAIRS) - occ_q);
        wr_en     = (fet_cnt != '0) && fet_ready && !flush;
        take_eff  = flush ? '0 : dsp_take;
    end

    ibuf_head_view #(
        .SLOTS (SLOTS),
        .LANES (LANES)
    ) u_head (
        .slots    (slots_q),
        .take_req (take_eff),
        .avail    (dsp_avail),
        .lanes    (lanes),
        .consume  (consume)
    );

    ibuf_pair_compact #(
        .NUM_PAIRS (NUM_PAIRS)
    ) u_compact (
        .slots     (slots_q),
        .consume   (consume),
        .kept      (kept),
        .occ_after (occ_after)
    );

    ibuf_pair_fill #(
        .NUM_PAIRS (NUM_PAIRS),
        .LANES     (LANES)
    ) u_fill (
        .base   (kept),
        .occ    (occ_after),
        .wr_en  (wr_en),
        .cnt    (fet_cnt),
        .group  (fet_instr),
        .filled (filled)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        assign dsp_instr[j*IB_INSTR_W +: IB_INSTR_W] = lanes[j];
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            slots_q <= '0;
        end else begin
            slots_q <= filled;
        end
    end

endmodule

// File: rtl/ibuf_pair_queue_chk.sv
module ibuf_pair_queue_chk #(
    parameter  int NUM_PAIRS = 4,
    parameter  int LANES     = 4,
    localparam int CNT_W     = $clog2(LANES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush,
    input logic [CNT_W-1:0] fet_cnt,
    input logic             fet_ready,
    input logic [CNT_W-1:0] dsp_avail,
    input logic [CNT_W-1:0] dsp_take
);

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> dsp_avail == '0); // R1

    AST_AVAIL_BOUND: assert property (@(posedge clk) disable iff (rst)
        dsp_avail <= CNT_W'(LANES)); // R2

    AST_BLOCKED_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!fet_ready && dsp_take == '0 && !flush) |=> $stable(dsp_avail)); // R3

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        flush |=> dsp_avail == '0); // R6

    AST_TAKE_CLAMP: assert property (@(posedge clk) disable iff (rst)
        (dsp_avail < CNT_W'(LANES) && dsp_take >= dsp_avail && fet_cnt == '0)
        |=> dsp_avail == '0); // R7

    AST_NO_GROWTH: assert property (@(posedge clk) disable iff (rst)
        (fet_cnt == '0 || !fet_ready) |=> dsp_avail <= $past(dsp_avail)); // R8

endmodule

bind ibuf_pair_queue ibuf_pair_queue_chk #(
    .NUM_PAIRS (NUM_PAIRS),
    .LANES     (LANES)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .fet_cnt   (fet_cnt),
    .fet_ready (fet_ready),
    .dsp_avail (dsp_avail),
    .dsp_take  (dsp_take)
);

// File: tb/ibuf_pair_queue_bench.sv
module ibuf_pair_queue_bench;
    import ibuf_pkg::*;

    localparam int NP = 4;
    localparam int LN = 4;
    localparam int W  = IB_INSTR_W;

    logic            clk = 1'b0;
    logic            rst;
    logic            flush;
    logic [2:0]      fet_cnt;
    logic [LN*W-1:0] fet_instr;
    logic            fet_ready;
    logic [2:0]      dsp_avail;
    logic [LN*W-1:0] dsp_instr;
    logic [2:0]      dsp_take;

    always #10 clk = ~clk;

    ibuf_pair_queue u_ibuf_pair_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .fet_cnt   (fet_cnt),
        .fet_instr (fet_instr),
        .fet_ready (fet_ready),
        .dsp_avail (dsp_avail),
        .dsp_instr (dsp_instr),
        .dsp_take  (dsp_take)
    );

    int          n_chk = 0;
    int          n_bad = 0;
    bit          done  = 0;
    instr_t      sbq[$];
    int          pq[$];
    int unsigned next_id = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // driver: offers a group, scoreboard pushes accepted items; monitor part pops on dispatch
    task automatic step(input int fc, input int tk, input bit fl, input string req);
        bit exp_ready;
        int exp_av;
        int t;
        int rem;
        fet_cnt  = 3'(fc);
        for (int l = 0; l < LN; l++) begin
            fet_instr[l*W +: W] = 32'hA500_0000 + next_id + l;
        end
        dsp_take = 3'(tk);
        flush    = fl;
        #2;
        exp_ready = ((fc + 1) / 2) <= (NP - pq.size());
        chk(fet_ready == exp_ready, req, "fet_ready", fet_ready, exp_ready);
        exp_av = (sbq.size() > LN) ? LN : sbq.size();
        chk(int'(dsp_avail) == exp_av, req, "dsp_avail", dsp_avail, exp_av);
        for (int j = 0; j < exp_av; j++) begin
            chk(dsp_instr[j*W +: W] == sbq[j], req, $sformatf("lane %0d", j),
                dsp_instr[j*W +: W], sbq[j]);
        end
        if (fl) begin
            sbq.delete();
            pq.delete();
        end else begin
            t = (tk > exp_av) ? exp_av : tk;
            for (int k = 0; k < t; k++) begin
                void'(sbq.pop_front());
                pq[0] = pq[0] - 1;
                if (pq[0] == 0) void'(pq.pop_front());
            end
            if (fc > 0 && exp_ready) begin
                rem = fc;
                while (rem > 0) begin
                    pq.push_back((rem >= 2) ? 2 : rem);
                    rem -= 2;
                end
                for (int l = 0; l < fc; l++) sbq.push_back(32'hA500_0000 + next_id + l);
                next_id += fc;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; flush = 1'b0; fet_cnt = '0; dsp_take = '0; fet_instr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: empty after reset, a full group fits
        fet_cnt = 3'd4;
        #2;
        chk(dsp_avail == 3'd0, "R1", "dsp_avail", dsp_avail, 0);
        chk(fet_ready == 1'b1, "R1", "fet_ready", fet_ready, 1);
        fet_cnt = 3'd0;
        @(negedge clk);
        step(0, 0, 0, "R8");   // nothing written
        step(0, 0, 0, "R8");
        // R4: groups take whole pairs
        step(4, 0, 0, "R4");
        step(3, 0, 0, "R4");
        step(1, 0, 0, "R3");   // four pairs used: blocked
        step(2, 0, 0, "R3");
        // R5: odd dispatch keeps leftover in the head pair
        step(1, 1, 0, "R5");   // still blocked (pre-dispatch occupancy)
        step(0, 3, 0, "R5");
        step(0, 1, 0, "R5");
        // R9: consume and append together
        step(3, 2, 0, "R9");
        step(2, 1, 0, "R9");
        step(1, 3, 0, "R9");
        // R7: over-request clamped
        step(0, 4, 0, "R7");
        step(0, 4, 0, "R7");
        step(0, 4, 0, "R7");
        step(2, 0, 0, "R7");
        step(0, 4, 0, "R7");
        // R6: flush drops contents and the offered group
        step(4, 0, 0, "R6");
        step(3, 1, 1, "R6");
        step(0, 0, 0, "R6");
        step(1, 0, 0, "R2");
        step(1, 0, 0, "R2");
        step(1, 0, 0, "R2");
        step(1, 0, 0, "R2");
        step(0, 4, 0, "R2");
        // random mix
        for (int i = 0; i < 600; i++) begin
            step($urandom_range(0, 4), $urandom_range(0, 4),
                 $urandom_range(0, 24) == 0, "R9");
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule